// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter that software reaches through a small byte-wide register bus. The counter has four register addresses: the low count byte, the high count byte, a control byte and an overflow flag byte. The counter advances on one of two event sources. The first is an internal tick at one quarter of the system clock rate. The second is an external clock pin, which can pass through a two-flop synchroniser or bypass it. Either source then goes through a prescaler of 1, 2, 4 or 8. When the count wraps from FFFFh to 0000h, a sticky overflow flag is raised and drives an interrupt request output.

Software can use the count bytes in two ways. In byte mode, each byte is read and written on its own. In wide mode, a high-byte buffer makes a 16-bit value move as a whole. Reading the low byte captures the high byte into the buffer. Writing the low byte commits the buffered high byte together with the new low byte.

Top module: `prescaled_timer16`

## Requirements
- R1: After reset the count is 0000h, the control byte reads 00h and the overflow flag is 0.
- R2: Address 2 holds the control byte. Bit 7 selects wide mode, bits 5:4 select the prescale, bit 2 bypasses the synchroniser, bit 1 selects the external source and bit 0 enables counting. Bits 6 and 3 always read 0, so writing FFh reads back B7h. Address 0 is the low count byte, address 1 is the high count byte and address 3 holds the flag in bit 0.
- R3: With the internal source and a 1:1 prescale, the count rises once every 4 clocks. The first step lands on the 4th clock edge after the last write to the control byte or to a count byte.
- R4: Prescale codes 00, 01, 10 and 11 divide the source events by 1, 2, 4 and 8. On the internal source this gives one step every 4, 8, 16 or 32 clocks. The count never rises by more than one per clock.
- R5: While the enable bit is 0, the count holds its value.
- R6: On the external source, only rising edges count, and only once a falling edge has been seen since the last control write. The prescale also applies to external edges.
- R7: On the external source with the synchroniser in use, a rising pin edge advances the count on the 3rd clock edge. With the bypass selected, it advances on the 1st clock edge. With the internal source, the bypass bit has no effect.
- R8: A step from FFFFh leaves the count at 0000h and sets the overflow flag on that same clock edge.
- R9: The flag stays set until a write to address 3 with bit 0 equal to 0. Writing bit 0 as 1 has no effect. If a clear and a wrap happen on the same edge, the flag ends up set.
- R10: In byte mode (bit 7 = 0), a write to one count byte leaves the other byte unchanged. Both bytes read back their live values.
- R11: In wide mode, a low-byte read copies the live high byte into the buffer, and high-byte reads return the buffer. A high-byte write loads only the buffer. A low-byte write loads the buffer and the data into the counter together.
- R12: A write to a count byte wins over an increment on the same edge. Any write to a count byte or to the control byte restarts the prescaler and the internal divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used by the wide-mode low-byte capture) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ext_clk | input | 1 | External count clock pin |
| ovf_flag | output | 1 | Sticky overflow flag / interrupt request |

## Verification
The internal source is run at every prescale code, with wait times on both sides of a step boundary. This separates the four division ratios from each other and from a wrong divide-by-four phase. The external pin is driven with a rise before any fall, then with complete pulses, in both synchroniser settings. This shows apart edge qualification, arming and the two-cycle synchroniser latency. Byte and wide accesses are interleaved so that a stale buffer, a high write applied too early or a missing read capture each give a different readback. Writes and flag clears are placed on the exact edge of an increment or a wrap to check which one takes priority.

// File: rtl/prescaled_timer16.sv
module prescaled_timer16 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ext_clk,
  output logic       ovf_flag
);
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTL = 2'd2, A_FLG = 2'd3;
  localparam int         CW   = 16;
  localparam logic [CW-1:0] CMAX = '1;

  logic          wide_mode, sync_off, src_ext, run;
  logic [1:0]    ps_sel;
  logic [CW-1:0] cnt_q;
  logic [7:0]    hi_buf;
  logic [1:0]    div_q;
  logic [2:0]    pre_q, pre_last;
  logic          ext_m, ext_s, ext_prev, armed;

  wire wr_lo    = bus_wr && bus_addr == A_LO;
  wire wr_hi    = bus_wr && bus_addr == A_HI;
  wire wr_ctl   = bus_wr && bus_addr == A_CTL;
  wire wr_flg   = bus_wr && bus_addr == A_FLG;
  wire cnt_wr   = wr_lo || wr_hi;
  wire restart  = cnt_wr || wr_ctl;

  wire ext_sel  = sync_off ? ext_clk : ext_s;
  wire ext_rise = ext_sel && !ext_prev;
  wire ext_fall = !ext_sel && ext_prev;
  wire src_evt  = src_ext ? (ext_rise && armed) : (div_q == 2'd3);

  always_comb begin
    case (ps_sel)
      2'd0:    pre_last = 3'd0;
      2'd1:    pre_last = 3'd1;
      2'd2:    pre_last = 3'd3;
      default: pre_last = 3'd7;
    endcase
  end

  wire pre_done = pre_q == pre_last;
  wire inc      = run && src_evt && pre_done && !cnt_wr;
  wire wrap     = inc && cnt_q == CMAX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {wide_mode, ps_sel, sync_off, src_ext, run} <= '0;
    end else if (wr_ctl) begin
      {wide_mode, ps_sel, sync_off, src_ext, run} <=
        {bus_wdata[7], bus_wdata[5:4], bus_wdata[2:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_m    <= 1'b0;
      ext_s    <= 1'b0;
      ext_prev <= 1'b0;
      armed    <= 1'b0;
    end else begin
      ext_m    <= ext_clk;
      ext_s    <= ext_m;
      ext_prev <= ext_sel;
      if (wr_ctl)        armed <= 1'b0;
      else if (ext_fall) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (restart) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      div_q <= div_q + 2'd1;
      if (run && src_evt) pre_q <= pre_done ? 3'd0 : pre_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (wr_lo)              cnt_q <= {wide_mode ? hi_buf : cnt_q[15:8], bus_wdata};
    else if (wr_hi && !wide_mode) cnt_q[15:8] <= bus_wdata;
    else if (inc)                cnt_q <= cnt_q + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   hi_buf <= '0;
    else if (wr_hi && wide_mode)                  hi_buf <= bus_wdata;
    else if (bus_rd && bus_addr == A_LO && wide_mode) hi_buf <= cnt_q[15:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ovf_flag <= 1'b0;
    else if (wrap)                    ovf_flag <= 1'b1;
    else if (wr_flg && !bus_wdata[0]) ovf_flag <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      A_LO:    bus_rdata = cnt_q[7:0];
      A_HI:    bus_rdata = wide_mode ? hi_buf : cnt_q[15:8];
      A_CTL:   bus_rdata = {wide_mode, 1'b0, ps_sel, 1'b0, sync_off, src_ext, run};
      default: bus_rdata = {7'b0, ovf_flag};
    endcase
  end
endmodule

module prescaled_timer16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        wide_mode,
  input logic        run,
  input logic [15:0] cnt,
  input logic        ovf_flag
);
  wire cnt_touch = bus_wr && bus_addr <= 2'd1;

  assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_touch) |=> cnt == $past(cnt));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_touch |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1));

  assert_flag_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (cnt == 16'h0000 && $past(cnt) == 16'hFFFF));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(bus_wr && bus_addr == 2'd3 && !bus_wdata[0])) |=> ovf_flag);

  assert_byte_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !wide_mode) |=> cnt[7:0] == $past(bus_wdata));
endmodule

bind prescaled_timer16 prescaled_timer16_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .wide_mode(wide_mode), .run(run), .cnt(cnt_q),
  .ovf_flag(ovf_flag)
);

// File: tb/prescaled_timer16_tb.sv
module prescaled_timer16_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, ext_clk = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic ovf_flag;
  int errors = 0, checks = 0;
  logic [15:0] got;
  logic [7:0] b;

  always #(CLK_P/2) clk = ~clk;

  prescaled_timer16 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk), .ovf_flag(ovf_flag)
  );

  // {control, wait cycles, expected count}
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {8'h01, 8'd40, 16'd10},  // R3
    {8'h11, 8'd40, 16'd5},   // R4 1:2
    {8'h21, 8'd48, 16'd3},   // R4 1:4
    {8'h31, 8'd70, 16'd2},   // R4 1:8
    {8'h31, 8'd31, 16'd0},   // R4 just before first step
    {8'h31, 8'd32, 16'd1},   // R4 first step
    {8'h05, 8'd40, 16'd10},  // R7 bypass bit ignored on internal
    {8'h00, 8'd40, 16'd0},   // R5 disabled
    {8'h03, 8'd40, 16'd0}    // R6 external, no edges
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] lo, hi;
    peek(2'd0, lo); peek(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setcnt(input logic [15:0] v, input logic [7:0] ctl);
    wr(2'd2, 8'h00); wr(2'd1, v[15:8]); wr(2'd0, v[7:0]); wr(2'd2, ctl);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    waitc(3); rst_n = 1'b1; waitc(1);
    // R1 reset state
    peek(2'd0, b); chk("R1 low", {8'h0, b}, 16'h0);
    peek(2'd1, b); chk("R1 high", {8'h0, b}, 16'h0);
    peek(2'd2, b); chk("R1 ctrl", {8'h0, b}, 16'h0);
    peek(2'd3, b); chk("R1 flag reg", {8'h0, b}, 16'h0);
    chk("R1 flag pin", {15'h0, ovf_flag}, 16'h0);

    // R2 control readback
    wr(2'd2, 8'hFF); peek(2'd2, b); chk("R2 ctrl readback", {8'h0, b}, 16'h00B7);
    wr(2'd2, 8'h00);

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      setcnt(16'h0000, VEC[i][31:24]);
      waitc(int'(VEC[i][23:16]));
      read16(got);
      chk($sformatf("R3/R4/R5/R6/R7 vector %0d", i), got, VEC[i][15:0]);
    end

    // R6 external edge qualification, bypass
    setcnt(16'h0000, 8'h07);
    ext_clk = 1'b1; waitc(3); read16(got); chk("R6 rise before fall", got, 16'd0);
    ext_clk = 1'b0; waitc(3); ext_clk = 1'b1; waitc(3);
    read16(got); chk("R6 first pulse", got, 16'd1);
    ext_clk = 1'b0; waitc(3); ext_clk = 1'b1; waitc(3);
    read16(got); chk("R6 second pulse", got, 16'd2);
    setcnt(16'h0000, 8'h17);
    ext_clk = 1'b0; waitc(3); ext_clk = 1'b1; waitc(3);
    read16(got); chk("R6 ext 1:2 one edge", got, 16'd0);
    ext_clk = 1'b0; waitc(3); ext_clk = 1'b1; waitc(3);
    read16(got); chk("R6 ext 1:2 two edges", got, 16'd1);

    // R7 latency with and without synchroniser
    setcnt(16'h0000, 8'h07);
    ext_clk = 1'b0; waitc(3); ext_clk = 1'b1; waitc(1);
    read16(got); chk("R7 bypass one edge", got, 16'd1);
    setcnt(16'h0000, 8'h03); waitc(3);
    ext_clk = 1'b0; waitc(4); ext_clk = 1'b1; waitc(2);
    read16(got); chk("R7 sync not yet", got, 16'd0);
    waitc(1); read16(got); chk("R7 sync third edge", got, 16'd1);

    // R8 wrap
    setcnt(16'hFFFE, 8'h01); waitc(7);
    read16(got); chk("R8 before wrap", got, 16'hFFFF);
    chk("R8 flag before wrap", {15'h0, ovf_flag}, 16'h0);
    waitc(1); read16(got); chk("R8 wrapped count", got, 16'h0000);
    chk("R8 flag set", {15'h0, ovf_flag}, 16'h1);

    // R9 sticky flag
    wr(2'd3, 8'h01); chk("R9 write one ignored", {15'h0, ovf_flag}, 16'h1);
    wr(2'd3, 8'h00); chk("R9 clear", {15'h0, ovf_flag}, 16'h0);
    setcnt(16'hFFFF, 8'h01); waitc(3);
    wr(2'd3, 8'h00);
    chk("R9 set wins over clear", {15'h0, ovf_flag}, 16'h1);
    read16(got); chk("R9 count at wrap", got, 16'h0000);
    wr(2'd3, 8'h00); chk("R9 cleared after", {15'h0, ovf_flag}, 16'h0);

    // R12 write priority and prescaler restart
    setcnt(16'h0000, 8'h01); waitc(3);
    wr(2'd0, 8'h50);
    read16(got); chk("R12 write wins", got, 16'h0050);
    waitc(3); read16(got); chk("R12 prescaler restarted", got, 16'h0050);
    waitc(1); read16(got); chk("R12 step after restart", got, 16'h0051);

    // R10 byte mode
    wr(2'd2, 8'h00); wr(2'd0, 8'h34); wr(2'd1, 8'h12);
    read16(got); chk("R10 byte writes", got, 16'h1234);
    wr(2'd1, 8'h56); read16(got); chk("R10 low kept", got, 16'h5634);

    // R11 wide mode
    wr(2'd2, 8'h80); wr(2'd1, 8'hAB); wr(2'd2, 8'h00);
    read16(got); chk("R11 high write buffered", got, 16'h5634);
    wr(2'd2, 8'h80); wr(2'd1, 8'hCD); wr(2'd0, 8'hEF); wr(2'd2, 8'h00);
    read16(got); chk("R11 atomic write", got, 16'hCDEF);
    wr(2'd2, 8'h80); rd(2'd0, b);
    wr(2'd2, 8'h00); wr(2'd1, 8'h11); wr(2'd2, 8'h80);
    peek(2'd1, b); chk("R11 high from buffer", {8'h0, b}, 16'h00CD);
    rd(2'd0, b); peek(2'd1, b); chk("R11 low read captures", {8'h0, b}, 16'h0011);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule